// File: doc/BRIEF.md
# Page Write Buffer Engine

This block sits behind a serial memory controller. It gathers the data bytes of one array-write command into a page-sized staging buffer. When the command closes cleanly, it copies the staged bytes into an on-chip memory array during a self-timed programming interval.

The controller supplies four things:
- a start pulse with the first target address;
- one strobe per received data byte;
- a pulse when chip select goes high;
- a flag that tells whether that rise landed exactly after a whole byte.

The engine returns three things:
- a busy flag, which is the write-in-progress status;
- a one-cycle pulse that tells the controller to clear its write-enable latch;
- the write strobes it applies to the array.

A read port on the array lets the surrounding logic fetch stored bytes. The busy interval has a fixed length of `WR_CYCLES` clocks, counted from the accepted chip-select rise. `WR_CYCLES` must be at least `PAGE_BYTES + 3` so that the copy into the array finishes inside the interval.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy`, `wel_clr` and `mem_we` are all 0.
- R2: A page is `PAGE_BYTES` (64) aligned bytes. The low 6 bits of `start_addr` select the first slot, and the upper bits select the page. The n-th data byte (n counted from 0) goes to page offset (start offset + n) mod 64. When more than 64 bytes arrive, a later byte overwrites an earlier byte in the same slot.
- R3: Only slots that received a byte are written to the array. Every other byte in the page, and every byte in other pages, keeps its contents.
- R4: A `cs_rise` with `on_boundary` = 0 discards the buffer. No array byte changes, and `busy` stays 0.
- R5: A `cs_rise` that comes before any data byte was received discards the command. No array byte changes, and `busy` stays 0.
- R6: An accepted `cs_rise` (with `on_boundary` = 1 and at least one byte received) makes `busy` 1 from the next cycle. `busy` then stays 1 for exactly `WR_CYCLES` cycles.
- R7: `wel_clr` is a single-cycle pulse in the first cycle after `busy` falls. It never occurs at any other time.
- R8: `mem_we` is 1 only while `busy` is 1.
- R9: While `busy` is 1, `cmd_start`, `byte_vld` and `cs_rise` have no effect on the array or the busy timing. A `byte_vld` in the same cycle as `cs_rise` is also ignored.
- R10: `rd_data` returns the array byte at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Opens a write command, honoured only when idle |
| start_addr | input | AW | First byte address of the command |
| byte_vld | input | 1 | One received data byte is on `byte_data` |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select went high in this cycle |
| on_boundary | input | 1 | The chip-select rise followed a complete byte |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array read data, one clock latency |
| busy | output | 1 | Write cycle in progress |
| wel_clr | output | 1 | Pulse to clear the controller's write-enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Take the clock edge that samples an accepted `cs_rise` as edge k:
- `busy` is visible after edge k and drops after edge k + `WR_CYCLES`.
- `wel_clr` appears in that same cycle and lasts one cycle.
- The write strobes appear between edge k+2 and edge k+65, because the buffer read and the output register each add one stage.
- A read returns its data one edge after the address is applied.

The bench model advances on each rising edge from the inputs alone. The bench compares every output at the following falling edge, so each result is checked in the exact cycle it is due. Array contents are read back only after the engine is idle again.

// File: rtl/page_write_engine_pkg.sv
package page_write_engine_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_FILL = 2'd1,
    PW_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int PAGE_BYTES = 64,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_mark,
  output logic          any_mark
);
  logic [7:0]            slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
    rd_data <= slot[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (clr)        mark_q <= '0;
    else if (wr_en) mark_q[wr_idx] <= 1'b1;
    rd_mark <= mark_q[rd_idx];
  end

  assign any_mark = |mark_q;
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
  parameter int WR_CYCLES = 1000000,
  localparam int CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last,
  output logic done
);
  logic [CW-1:0] cnt_q;

  assign last = busy && (cnt_q == CW'(WR_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pw_array.sv
module pw_array #(
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import page_write_engine_pkg::*;
#(
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 1000000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int BW = AW - PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_start,
  input  logic [AW-1:0] start_addr,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          cs_rise,
  input  logic          on_boundary,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          wel_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  pw_state_e     state_q;
  logic [BW-1:0] base_q;
  logic [PW-1:0] ptr_q;
  logic [PW:0]   sweep_q;
  logic          sweep_on_q;
  logic          s1_vld_q;
  logic [PW-1:0] s1_idx_q;

  logic          buf_clr, buf_wr, buf_mark, any_mark;
  logic [7:0]    buf_rd;
  logic          commit, tmr_last;

  assign buf_clr = (state_q == PW_IDLE) && cmd_start;
  assign buf_wr  = (state_q == PW_FILL) && byte_vld && !cs_rise;
  assign commit  = (state_q == PW_FILL) && cs_rise && on_boundary && any_mark;

  pw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .clr      (buf_clr),
    .wr_en    (buf_wr),
    .wr_idx   (ptr_q),
    .wr_data  (byte_data),
    .rd_idx   (sweep_q[PW-1:0]),
    .rd_data  (buf_rd),
    .rd_mark  (buf_mark),
    .any_mark (any_mark)
  );

  pw_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (commit),
    .busy  (busy),
    .last  (tmr_last),
    .done  (wel_clr)
  );

  pw_array #(.AW(AW)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PW_IDLE;
      base_q     <= '0;
      ptr_q      <= '0;
      sweep_q    <= '0;
      sweep_on_q <= 1'b0;
    end else begin
      case (state_q)
        PW_IDLE: if (cmd_start) begin
          base_q  <= start_addr[AW-1:PW];
          ptr_q   <= start_addr[PW-1:0];
          state_q <= PW_FILL;
        end
        PW_FILL: begin
          if (cs_rise) begin
            if (commit) begin
              state_q    <= PW_PROG;
              sweep_q    <= '0;
              sweep_on_q <= 1'b1;
            end else begin
              state_q <= PW_IDLE;
            end
          end else if (byte_vld) begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        PW_PROG: begin
          if (sweep_on_q) begin
            sweep_q <= sweep_q + 1'b1;
            if (sweep_q == (PW+1)'(PAGE_BYTES - 1)) sweep_on_q <= 1'b0;
          end
          if (tmr_last) state_q <= PW_IDLE;
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld_q  <= 1'b0;
      s1_idx_q  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      s1_vld_q  <= sweep_on_q;
      s1_idx_q  <= sweep_q[PW-1:0];
      mem_we    <= s1_vld_q && buf_mark;
      mem_addr  <= {base_q, s1_idx_q};
      mem_wdata <= buf_rd;
    end
  end
endmodule

// File: rtl/page_write_engine_chk.sv
module page_write_engine_chk #(
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 1000000,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_rise,
  input logic          on_boundary,
  input logic          busy,
  input logic          wel_clr,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-PW-1:0] base_q
);
  logic [31:0] run_len;
  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= '0;
    else              run_len <= run_len + 1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!busy && !wel_clr && !mem_we));
  a_r4_no_busy_bad_edge: assert property (@(posedge clk) disable iff (rst)
    (!busy && cs_rise && !on_boundary) |=> !busy);
  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 32'(WR_CYCLES)));
  a_r7_wel_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> wel_clr);
  a_r7_wel_only_on_fall: assert property (@(posedge clk) disable iff (rst)
    wel_clr |-> (!busy && $past(busy)));
  a_r8_we_inside_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  a_r2_we_in_page: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AW-1:PW] == base_q));
endmodule

bind page_write_engine page_write_engine_chk #(
  .AW(AW), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cs_rise(cs_rise), .on_boundary(on_boundary),
  .busy(busy), .wel_clr(wel_clr), .mem_we(mem_we), .mem_addr(mem_addr),
  .base_q(base_q)
);

// File: tb/page_write_engine_tb.sv
`timescale 1ns/1ps
module page_write_engine_tb;
  localparam int AW = 10;
  localparam int PB = 64;
  localparam int WC = 80;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic cmd_start = 0, byte_vld = 0, cs_rise = 0, on_boundary = 0;
  logic [AW-1:0] start_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0;
  logic [7:0] rd_data, mem_wdata;
  logic busy, wel_clr, mem_we;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  page_write_engine #(.AW(AW), .PAGE_BYTES(PB), .WR_CYCLES(WC)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .on_boundary(on_boundary), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .wel_clr(wel_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  int checks = 0, errors = 0, cyc = 0;

  // behavioural reference model
  logic [7:0]  m_mem [DEPTH];
  bit          m_coll;
  int          m_base, m_ptr, m_busy_left, m_strobes, m_cbase, m_cnt;
  bit          m_wel;
  bit [PB-1:0] m_mask, m_cmask;
  logic [7:0]  m_buf [PB];
  logic [7:0]  m_cbuf [PB];

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      m_coll = 0; m_busy_left = 0; m_wel = 0;
    end else begin
      m_wel = 0;
      if (m_busy_left > 0) begin
        m_busy_left--;
        if (m_busy_left == 0) m_wel = 1;
      end else if (!m_coll) begin
        if (cmd_start) begin
          m_coll = 1; m_base = int'(start_addr) / PB * PB;
          m_ptr = int'(start_addr) % PB; m_mask = '0;
        end
      end else if (cs_rise) begin
        m_coll = 0;
        if (on_boundary && m_mask != 0) begin
          m_busy_left = WC; m_cbase = m_base; m_cmask = m_mask;
          m_strobes = 0; m_cnt = $countones(m_mask);
          for (int i = 0; i < PB; i++) begin
            m_cbuf[i] = m_buf[i];
            if (m_mask[i]) m_mem[m_base + i] = m_buf[i];
          end
        end
      end else if (byte_vld) begin
        m_buf[m_ptr] = byte_data; m_mask[m_ptr] = 1; m_ptr = (m_ptr + 1) % PB;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(busy == (m_busy_left > 0), "R6 busy", busy, m_busy_left > 0);
      chk(wel_clr == m_wel, "R7 wel_clr", wel_clr, m_wel);
      if (mem_we) begin
        int idx;
        idx = int'(mem_addr) % PB;
        chk(busy, "R8 strobe while busy", busy, 1);
        chk(int'(mem_addr) - idx == m_cbase && m_cmask[idx], "R3 strobe address", mem_addr, m_cbase + idx);
        chk(mem_wdata == m_cbuf[idx], "R2 strobe data", mem_wdata, m_cbuf[idx]);
        m_strobes++;
      end
      if (m_wel) chk(m_strobes == m_cnt, "R3 strobe count", m_strobes, m_cnt);
    end
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      report();
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cmd(input int a);
    cmd_start = 1; start_addr = AW'(a); @(negedge clk); cmd_start = 0;
  endtask
  task automatic put(input int d);
    byte_vld = 1; byte_data = 8'(d); @(negedge clk); byte_vld = 0;
  endtask
  task automatic close(input bit b);
    cs_rise = 1; on_boundary = b; @(negedge clk); cs_rise = 0; on_boundary = 0;
  endtask
  task automatic settle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic rd(input int a, input int exp, input string req);
    rd_addr = AW'(a); @(negedge clk);
    chk(rd_data == 8'(exp), req, rd_data, exp);
  endtask
  task automatic rd_model(input int lo, input int hi, input string req);
    for (int a = lo; a < hi; a++) rd(a, m_mem[a], req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !wel_clr && !mem_we, "R1 reset outputs", {busy, wel_clr, mem_we}, 0);
    rst = 0;
    @(negedge clk);

    // R2/R3: short write inside page 1
    cmd(12'h045);
    for (int n = 0; n < 4; n++) put(8'hA0 + n);
    close(1);
    @(negedge clk);
    chk(busy, "R6 busy after accept", busy, 1);
    settle();
    rd(12'h045, 8'hA0, "R2 first byte");
    rd(12'h048, 8'hA3, "R2 last byte");
    rd(12'h044, 8'h00, "R3 below untouched");
    rd(12'h049, 8'h00, "R3 above untouched");
    rd_model(12'h040, 12'h080, "R10 page 1 readback");

    // R2: 70 bytes from offset 62 of page 2 wrap and overwrite
    cmd(12'h0BE);
    for (int n = 0; n < 70; n++) put(8'h30 + n);
    close(1);
    settle();
    rd(12'h0BE, 8'h70, "R2 wrap overwrite slot 62");
    rd(12'h080, 8'h72, "R2 wrap overwrite slot 0");
    rd(12'h084, 8'h36, "R2 wrap slot 4");
    rd_model(12'h080, 12'h0C0, "R2 page 2 readback");

    // R4: rise not on a byte boundary
    cmd(12'h0C3);
    for (int n = 0; n < 5; n++) put(8'h55);
    close(0);
    @(negedge clk);
    chk(!busy, "R4 no busy on bad edge", busy, 0);
    settle();
    rd(12'h0C3, 8'h00, "R4 array unchanged");
    rd(12'h0C7, 8'h00, "R4 array unchanged end");

    // R5: rise before any byte
    cmd(12'h100);
    close(1);
    @(negedge clk);
    chk(!busy, "R5 no busy without data", busy, 0);
    settle();
    rd(12'h100, 8'h00, "R5 array unchanged");

    // R9: traffic during busy is ignored; byte with cs_rise ignored
    cmd(12'h140);
    put(8'h11); put(8'h22);
    byte_vld = 1; byte_data = 8'hEE; close(1); byte_vld = 0;
    repeat (3) @(negedge clk);
    cmd(12'h180);
    put(8'h99); put(8'h98);
    close(1);
    settle();
    rd(12'h142, 8'h00, "R9 byte with rise dropped");
    rd(12'h180, 8'h00, "R9 busy command ignored");
    rd(12'h181, 8'h00, "R9 busy command ignored 2");
    rd(12'h141, 8'h22, "R9 own data kept");

    // R3: single byte overwrite keeps neighbours
    cmd(12'h046);
    put(8'h5A);
    close(1);
    settle();
    rd(12'h046, 8'h5A, "R3 single byte");
    rd(12'h045, 8'hA0, "R3 neighbour kept");
    rd(12'h047, 8'hA2, "R3 neighbour kept 2");
    rd_model(12'h000, 12'h200, "R10 full readback");

    report();
  end
endmodule